// File: doc/BRIEF.md
# Software Interrupt Acceptance Filter

This block sits between the sources of software-generated interrupts and the pending storage of one processor's interrupt controller slice. It handles sixteen interrupt IDs. Each incoming request carries a requested group, an ID and a flag marking a non-secure sender. The block sets the pending bit of that ID only if the request passes two checks. The first is a group check against the configured group of the ID, with one allowed downgrade. The second, for non-secure senders while security is enabled, is a per-ID two-bit permission level. When a request passes, the block raises a single-cycle set-pending strobe with the ID one cycle after the request.

The configured group of each ID comes from two 16-bit vectors supplied by the surrounding controller. The permission levels sit in a 32-bit access word that the block holds itself. Only secure register accesses may read or write that word, and only while security is enabled.

Top module: `swirq_gate`

## Requirements
- R1: The permission level for ID n is bits [2n+1:2n] of the access word, for n from 0 to 15.
- R2: A request for secure group 1 (code 1) aimed at an ID whose configured group is group 0 is handled as a group 0 request.
- R3: After the adjustment of R2, a request whose group code differs from the configured group of the ID is dropped. Group codes are 0 for group 0, 1 for secure group 1 and 2 for non-secure group 1. Code 3 matches no ID.
- R4: While security is enabled and the sender is non-secure, the permission level must meet a threshold or the request is dropped. The threshold is at least 1 for an ID in group 0 and at least 2 for an ID in secure group 1. An ID in non-secure group 1 needs no particular level.
- R5: `acceptPulse` is high for exactly one cycle, with `acceptId` equal to the request ID, in the cycle after a request that passes. It stays low after any cycle without a passing request.
- R6: When security is disabled or the register access is non-secure, the access word reads as zero and writes to it have no effect.
- R7: The configured group of ID n is non-secure group 1 when `grpVec[n]` is 1. It is secure group 1 when `grpVec[n]` is 0 and `grpModVec[n]` is 1. It is group 0 when both bits are 0.
- R8: While security is disabled, the non-secure flag of a request is ignored and only the group check decides.
- R9: After reset the access word is zero and `acceptPulse` is low.
- R10: A request in the same cycle as an accepted access-word write is judged against the word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secDisable | input | 1 | Global security-disable flag |
| grpVec | input | 16 | Per-ID group bit |
| grpModVec | input | 16 | Per-ID group modifier bit |
| reqValid | input | 1 | Request strobe |
| reqGroup | input | 2 | Requested group code |
| reqId | input | 4 | Requested interrupt ID |
| reqNs | input | 1 | Request comes from a non-secure sender |
| regWrEn | input | 1 | Access-word write strobe |
| regSecure | input | 1 | Register access is secure |
| regWrData | input | 32 | Access-word write data |
| regRdData | output | 32 | Access-word read data, combinational |
| acceptPulse | output | 1 | Set-pending strobe |
| acceptId | output | 4 | ID to set pending |

## Verification
A write to the access word and a permission check on a request can land on the same clock edge. The bench provokes this by driving a secure write and a non-secure request for the same ID in one cycle. The write raises that ID's level from 0 to 1. The request must still be dropped, because it is judged against the old level. A repeat request one cycle later must be accepted, which shows the write did take effect.

// File: rtl/swirq_pkg.sv
package swirq_pkg;
  localparam int NUM_IDS = 16;
  localparam int FIELD_W = 2;
  localparam int ID_W    = $clog2(NUM_IDS);
  localparam int WORD_W  = NUM_IDS * FIELD_W;

  typedef enum logic [1:0] {
    GRP_0    = 2'd0,
    GRP_1S   = 2'd1,
    GRP_1NS  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic            acceptSet;
    logic [ID_W-1:0] acceptId;
    logic            accessWr;
  } ctrl_s;
endpackage

// File: rtl/swirq_ctrl.sv
module swirq_ctrl
  import swirq_pkg::*;
(
  input  logic               secDisable,
  input  logic [NUM_IDS-1:0] grpVec,
  input  logic [NUM_IDS-1:0] grpModVec,
  input  logic               reqValid,
  input  logic [1:0]         reqGroup,
  input  logic [ID_W-1:0]    reqId,
  input  logic               reqNs,
  input  logic               regWrEn,
  input  logic               regSecure,
  input  logic [WORD_W-1:0]  accessWord,
  output ctrl_s              ctrlOut
);
  grp_e               cfgArr   [NUM_IDS];
  logic [FIELD_W-1:0] fieldArr [NUM_IDS];

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_perId
    assign fieldArr[g] = accessWord[g*FIELD_W +: FIELD_W];
    assign cfgArr[g]   = grpVec[g]    ? GRP_1NS :
                         grpModVec[g] ? GRP_1S  : GRP_0;
  end

  grp_e               cfgGrp;
  grp_e               effGrp;
  logic [FIELD_W-1:0] level;
  logic               grpMatch;
  logic               permOk;

  always_comb begin
    cfgGrp = cfgArr[reqId];
    level  = fieldArr[reqId];
    effGrp = grp_e'(reqGroup);
    if (effGrp == GRP_1S && cfgGrp == GRP_0) effGrp = GRP_0;
    grpMatch = (effGrp == cfgGrp);
    if (secDisable || !reqNs) begin
      permOk = 1'b1;
    end else begin
      unique case (cfgGrp)
        GRP_0:   permOk = (level >= FIELD_W'(1));
        GRP_1S:  permOk = (level >= FIELD_W'(2));
        default: permOk = 1'b1;
      endcase
    end
    ctrlOut.acceptSet = reqValid && grpMatch && permOk;
    ctrlOut.acceptId  = reqId;
    ctrlOut.accessWr  = regWrEn && regSecure && !secDisable;
  end
endmodule

// File: rtl/swirq_datapath.sv
module swirq_datapath
  import swirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_s             ctrlIn,
  input  logic              rdAllowed,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] accessWord,
  output logic [WORD_W-1:0] regRdData,
  output logic              acceptPulse,
  output logic [ID_W-1:0]   acceptId
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accessWord  <= '0;
      acceptPulse <= 1'b0;
      acceptId    <= '0;
    end else begin
      if (ctrlIn.accessWr) accessWord <= regWrData;
      acceptPulse <= ctrlIn.acceptSet;
      if (ctrlIn.acceptSet) acceptId <= ctrlIn.acceptId;
    end
  end

  assign regRdData = rdAllowed ? accessWord : '0;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (acceptPulse && !$past(ctrlIn.acceptSet)) |-> 1'b0) else $error("pulse"); // R5
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlIn.accessWr) |-> $stable(accessWord)) else $error("hold"); // R6
endmodule

// File: rtl/swirq_gate.sv
module swirq_gate
  import swirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secDisable,
  input  logic [15:0]       grpVec,
  input  logic [15:0]       grpModVec,
  input  logic              reqValid,
  input  logic [1:0]        reqGroup,
  input  logic [3:0]        reqId,
  input  logic              reqNs,
  input  logic              regWrEn,
  input  logic              regSecure,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              acceptPulse,
  output logic [3:0]        acceptId
);
  ctrl_s             ctrlBus;
  logic [WORD_W-1:0] accessWord;

  swirq_ctrl u_ctrl (
    .secDisable (secDisable),
    .grpVec     (grpVec),
    .grpModVec  (grpModVec),
    .reqValid   (reqValid),
    .reqGroup   (reqGroup),
    .reqId      (reqId),
    .reqNs      (reqNs),
    .regWrEn    (regWrEn),
    .regSecure  (regSecure),
    .accessWord (accessWord),
    .ctrlOut    (ctrlBus)
  );

  swirq_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlIn      (ctrlBus),
    .rdAllowed   (regSecure && !secDisable),
    .regWrData   (regWrData),
    .accessWord  (accessWord),
    .regRdData   (regRdData),
    .acceptPulse (acceptPulse),
    .acceptId    (acceptId)
  );

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !acceptPulse) else $error("spurious"); // R5
  AST_ID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !$isunknown(reqId)) |=> (!acceptPulse || acceptId == $past(reqId))) else $error("id"); // R5
  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (secDisable || !regSecure)) |=> $stable(accessWord)) else $error("blocked"); // R6
  AST_NS_LEVEL0: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqNs && !secDisable && !grpVec[reqId]
     && accessWord[{reqId, 1'b0} +: 2] == 2'd0) |=> !acceptPulse) else $error("perm"); // R4
  AST_NSG1_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqGroup == 2'd2 && !grpVec[reqId]) |=> !acceptPulse) else $error("grp"); // R3
endmodule

// File: tb/tb_swirq_gate.sv
module tb_swirq_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ACC_WORD = 32'h00E4_00E4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secDisable = 1'b0;
  logic [15:0] grpVec = 16'hF000;     // ids 12..15 non-secure G1 (R7)
  logic [15:0] grpModVec = 16'h0F00;  // ids 8..11 secure G1, 0..7 G0 (R7)
  logic        reqValid = 1'b0;
  logic [1:0]  reqGroup = '0;
  logic [3:0]  reqId = '0;
  logic        reqNs = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSecure = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        acceptPulse;
  logic [3:0]  acceptId;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swirq_gate dut (.*);

  // vector: {secDis, ns, grp[1:0], id[3:0], expect, reqNum[3:0]}
  // access levels: id1=1 id2=2 id3=3 id9=1 id10=2 id11=3, rest 0 (R1)
  localparam logic [12:0] VEC [20] = '{
    {1'b0, 1'b0, 2'd0, 4'd0,  1'b1, 4'd3},  // R3 secure G0 match
    {1'b0, 1'b1, 2'd0, 4'd0,  1'b0, 4'd4},  // R4 level 0 too low
    {1'b0, 1'b1, 2'd0, 4'd1,  1'b1, 4'd1},  // R1 id1 level 1
    {1'b0, 1'b1, 2'd0, 4'd3,  1'b1, 4'd4},  // R4
    {1'b0, 1'b0, 2'd1, 4'd2,  1'b1, 4'd2},  // R2 downgrade
    {1'b0, 1'b1, 2'd1, 4'd1,  1'b1, 4'd2},  // R2 downgrade, level 1
    {1'b0, 1'b1, 2'd1, 4'd0,  1'b0, 4'd2},  // R2 downgrade, level 0
    {1'b0, 1'b0, 2'd2, 4'd4,  1'b0, 4'd3},  // R3 G1NS to G0
    {1'b0, 1'b0, 2'd0, 4'd8,  1'b0, 4'd3},  // R3 G0 to G1S
    {1'b0, 1'b0, 2'd1, 4'd8,  1'b1, 4'd7},  // R7 secure G1 id
    {1'b0, 1'b1, 2'd1, 4'd9,  1'b0, 4'd4},  // R4 level 1 < 2
    {1'b0, 1'b1, 2'd1, 4'd10, 1'b1, 4'd4},  // R4 level 2
    {1'b0, 1'b1, 2'd1, 4'd11, 1'b1, 4'd1},  // R1 id11 level 3
    {1'b0, 1'b1, 2'd2, 4'd12, 1'b1, 4'd4},  // R4 G1NS no level
    {1'b0, 1'b0, 2'd1, 4'd12, 1'b0, 4'd7},  // R7 id12 is G1NS
    {1'b1, 1'b1, 2'd0, 4'd0,  1'b1, 4'd8},  // R8 ns ignored
    {1'b1, 1'b1, 2'd1, 4'd8,  1'b1, 4'd8},  // R8
    {1'b1, 1'b1, 2'd2, 4'd4,  1'b0, 4'd8},  // R8 group check stays
    {1'b0, 1'b0, 2'd2, 4'd13, 1'b1, 4'd3},  // R3
    {1'b0, 1'b0, 2'd3, 4'd0,  1'b0, 4'd3}   // R3 code 3 matches none
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [31:0] d, input logic sec);
    @(negedge clk);
    regWrEn = 1'b1; regSecure = sec; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // drives one request, samples the registered result one cycle later
  task automatic sendReq(input logic ns, input logic [1:0] g, input logic [3:0] id,
                         input logic exp, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqNs = ns; reqGroup = g; reqId = id;
    @(negedge clk);
    reqValid = 1'b0;
    check(acceptPulse == exp, req, {31'd0, acceptPulse}, {31'd0, exp});
    if (exp) check(acceptId == id, req, {28'd0, acceptId}, {28'd0, id});
    @(negedge clk);
    check(acceptPulse == 1'b0, "R5 single", {31'd0, acceptPulse}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regSecure = 1'b1;
    check(acceptPulse == 1'b0, "R9 pulse", {31'd0, acceptPulse}, 32'd0);
    check(regRdData == 32'd0, "R9 word", regRdData, 32'd0);

    regWrite(32'hFFFF_FFFF, 1'b0);     // non-secure write ignored
    regSecure = 1'b1; #1;
    check(regRdData == 32'd0, "R6 ns write", regRdData, 32'd0);
    secDisable = 1'b1;
    regWrite(32'hFFFF_FFFF, 1'b1);     // security disabled write ignored
    secDisable = 1'b0; regSecure = 1'b1; #1;
    check(regRdData == 32'd0, "R6 secdis write", regRdData, 32'd0);

    regWrite(ACC_WORD, 1'b1);
    regSecure = 1'b1; #1;
    check(regRdData == ACC_WORD, "R1 readback", regRdData, ACC_WORD);
    regSecure = 1'b0; #1;
    check(regRdData == 32'd0, "R6 ns read", regRdData, 32'd0);
    regSecure = 1'b1; secDisable = 1'b1; #1;
    check(regRdData == 32'd0, "R6 secdis read", regRdData, 32'd0);
    secDisable = 1'b0;

    for (int i = 0; i < 20; i++) begin
      secDisable = VEC[i][12];
      sendReq(VEC[i][11], VEC[i][10:9], VEC[i][8:5], VEC[i][4],
              $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end
    secDisable = 1'b0;

    // R10: write id0 level 1 in same cycle as ns G0 request on id0
    @(negedge clk);
    regWrEn = 1'b1; regSecure = 1'b1; regWrData = ACC_WORD | 32'h1;
    reqValid = 1'b1; reqNs = 1'b1; reqGroup = 2'd0; reqId = 4'd0;
    @(negedge clk);
    regWrEn = 1'b0; reqValid = 1'b0;
    check(acceptPulse == 1'b0, "R10 old level", {31'd0, acceptPulse}, 32'd0);
    sendReq(1'b1, 2'd0, 4'd0, 1'b1, "R10 new level");

    summary();
  end
endmodule